// File: doc/BRIEF.md
# Multi-CPU Interrupt Routing Controller

This block steers 32 level-sensitive interrupt sources onto four CPU interrupt lines. Every source owns one routing record: a mask bit for each CPU and, for shared sources, a global enable bit. Sources 0 to 7 are per-CPU sources. Each CPU has its own raw input for each of them, and they have no global enable. Sources 8 to 31 are shared. Each has a single raw input, and it reaches a CPU only when both its global enable and that CPU's mask bit are set.

Software reaches the mask bits through two address windows that share one storage array. In the per-source window, each source has a control word whose low bits are its CPU mask. In the per-CPU window, each CPU has a set address and a clear address, and the written data names an interrupt number. A write made through either window can be read back through the other. A shared source must be routed to at most one CPU. Any write that leaves a shared source with two or more CPU bits set raises a sticky error flag, which only reset clears.

The register port uses word addresses. It has a write strobe and a read strobe, and read data appears one cycle after the read strobe. Each CPU line is the registered OR of every source that is live for that CPU.

Top module: `irq_route_top`

## Requirements
- R1: After reset all mask bits and global enables are clear. `cpuIrq` is 0, `errSticky` is 0 and `busRdData` is 0.
- R2: A write to address s, where s is 0 to 31, loads `busWrData[3:0]` into source s's CPU mask, with bit c standing for CPU c. A read of address s returns that mask in bits [3:0] with every higher bit zero.
- R3: A write to address 0x40+c sets, and a write to 0x44+c clears, CPU c's mask bit for the interrupt number in `busWrData[7:0]`. A read of 0x40+c or 0x44+c returns CPU c's 32-bit mask vector, with bit n standing for source n.
- R4: Both windows address the same bits, so a change made through one is visible on a read through the other.
- R5: A per-CPU set or clear write whose number is 32 or more changes nothing. A global-enable write whose number is outside 8 to 31 changes nothing.
- R6: A write to 0x48 sets, and a write to 0x49 clears, the global enable of the shared source numbered in `busWrData[7:0]`.
- R7: Shared source n (8 to 31) asserts `cpuIrq[c]` only while `shLevel[n-8]` is high, its global enable is set and CPU c's mask bit n is set.
- R8: Per-CPU source i (0 to 7) asserts `cpuIrq[c]` while `pcLevel[c*8+i]` and CPU c's mask bit i are both set. No global enable is involved.
- R9: `cpuIrq` is registered. It reflects the levels and routing state one clock edge after they change, and it holds its value while neither the levels nor the state change.
- R10: `busRdData` is valid in the cycle after `busRdEn`. It is zero in any cycle that follows no read, and after a read of an unmapped address.
- R11: `errSticky` is set at the edge of any write that leaves a shared source with more than one CPU bit set, whichever window the write used. It then stays set until reset. Per-CPU sources may route to several CPUs without raising it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busAddr | input | 8 | Word address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, one cycle after busRdEn |
| shLevel | input | 24 | Raw levels of shared sources 8 to 31 |
| pcLevel | input | 32 | Raw per-CPU levels; bit c*8+i is source i for CPU c |
| cpuIrq | output | 4 | Level interrupt line for each CPU |
| errSticky | output | 1 | Sticky flag for a shared source routed to more than one CPU |

## Verification
A write changes the routing state at the edge that samples it, so the error flag can be checked on the very next falling edge. The CPU lines take one edge more, so they are due on the falling edge that follows the next rising edge. A change on a raw level shows up on the CPU lines after a single edge. The bench drives all inputs on falling edges and reads each result on the falling edge at which it is due. The bench also checks the line once a cycle too early, which shows that the output register is really there. Expected read data is queued at the moment the read strobe is driven, and it is compared one edge later when the monitor sees that the strobe was sampled.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  // Decoded operation strobes passed from control to datapath
  typedef struct packed {
    logic srcWr;   // per-source mask word write
    logic cpuSet;  // per-CPU set by number
    logic cpuClr;  // per-CPU clear by number
    logic genSet;  // shared global enable set
    logic genClr;  // shared global enable clear
    logic rdSrc;   // read per-source mask word
    logic rdCpu;   // read per-CPU mask vector
  } routeStb_t;

endpackage

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int NUM_CPUS   = 4,
  parameter int NUM_SRC    = 32,
  parameter int NUM_PERCPU = 8,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int NUM_W      = 8,
  parameter int SET_BASE   = 64,
  localparam int IDX_W     = $clog2(NUM_SRC),
  localparam int CPU_W     = $clog2(NUM_CPUS)
) (
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output routeStb_t         stb,
  output logic [IDX_W-1:0]  wrIdx,
  output logic [IDX_W-1:0]  rdIdx,
  output logic [CPU_W-1:0]  cpuSel,
  output logic [NUM_CPUS-1:0] wrMask
);

  localparam logic [ADDR_W-1:0] SRC_END   = ADDR_W'(NUM_SRC);
  localparam logic [ADDR_W-1:0] SET_LO    = ADDR_W'(SET_BASE);
  localparam logic [ADDR_W-1:0] CLR_LO    = ADDR_W'(SET_BASE + NUM_CPUS);
  localparam logic [ADDR_W-1:0] GEN_SET_A = ADDR_W'(SET_BASE + 2*NUM_CPUS);
  localparam logic [ADDR_W-1:0] GEN_CLR_A = ADDR_W'(SET_BASE + 2*NUM_CPUS + 1);
  localparam logic [NUM_W-1:0]  NUM_LIM   = NUM_W'(NUM_SRC);
  localparam logic [NUM_W-1:0]  SH_LO     = NUM_W'(NUM_PERCPU);

  logic [NUM_W-1:0] numFld;
  logic inSrc, inSet, inClr, numOk, shOk;
  logic unusedWdHi;

  assign numFld     = busWrData[NUM_W-1:0];
  assign unusedWdHi = ^busWrData[DATA_W-1:NUM_W];

  assign inSrc = busAddr < SRC_END;
  assign inSet = (busAddr >= SET_LO) && (busAddr < CLR_LO);
  assign inClr = (busAddr >= CLR_LO) && (busAddr < GEN_SET_A);
  assign numOk = numFld < NUM_LIM;
  assign shOk  = numOk && (numFld >= SH_LO);

  always_comb begin
    stb        = '0;
    stb.srcWr  = busWrEn && inSrc;
    stb.cpuSet = busWrEn && inSet && numOk;
    stb.cpuClr = busWrEn && inClr && numOk;
    stb.genSet = busWrEn && (busAddr == GEN_SET_A) && shOk;
    stb.genClr = busWrEn && (busAddr == GEN_CLR_A) && shOk;
    stb.rdSrc  = busRdEn && inSrc;
    stb.rdCpu  = busRdEn && (inSet || inClr);
  end

  assign wrIdx  = inSrc ? busAddr[IDX_W-1:0] : numFld[IDX_W-1:0];
  assign rdIdx  = busAddr[IDX_W-1:0];
  assign cpuSel = inSet ? CPU_W'(busAddr - SET_LO) : CPU_W'(busAddr - CLR_LO);
  assign wrMask = busWrData[NUM_CPUS-1:0];

endmodule

// File: rtl/irq_route_dp.sv
module irq_route_dp
  import irq_route_pkg::*;
#(
  parameter int NUM_CPUS   = 4,
  parameter int NUM_SRC    = 32,
  parameter int NUM_PERCPU = 8,
  parameter int DATA_W     = 32,
  localparam int IDX_W     = $clog2(NUM_SRC),
  localparam int CPU_W     = $clog2(NUM_CPUS),
  localparam int NUM_SH    = NUM_SRC - NUM_PERCPU
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  routeStb_t                    stb,
  input  logic [IDX_W-1:0]             wrIdx,
  input  logic [IDX_W-1:0]             rdIdx,
  input  logic [CPU_W-1:0]             cpuSel,
  input  logic [NUM_CPUS-1:0]          wrMask,
  input  logic [NUM_SH-1:0]            shLevel,
  input  logic [NUM_CPUS*NUM_PERCPU-1:0] pcLevel,
  output logic [DATA_W-1:0]            rdData,
  output logic [NUM_CPUS-1:0]          cpuIrq,
  output logic                         errSticky
);

  // One storage array serves both register windows
  logic [NUM_SRC-1:0] cpuMask  [NUM_CPUS];
  logic [NUM_SRC-1:0] maskNext [NUM_CPUS];
  logic [NUM_SH-1:0]  genEn, genNext;
  logic [IDX_W-1:0]   shIdx;
  logic               errSet;
  logic [NUM_CPUS-1:0] hit;
  logic [NUM_CPUS-1:0] srcCol;
  logic [DATA_W-1:0]  rdNext;

  assign shIdx = wrIdx - IDX_W'(NUM_PERCPU);

  always_comb begin
    maskNext = cpuMask;
    genNext  = genEn;
    if (stb.srcWr) begin
      for (int c = 0; c < NUM_CPUS; c++) maskNext[c][wrIdx] = wrMask[c];
    end
    if (stb.cpuSet) maskNext[cpuSel][wrIdx] = 1'b1;
    if (stb.cpuClr) maskNext[cpuSel][wrIdx] = 1'b0;
    if (stb.genSet) genNext[shIdx] = 1'b1;
    if (stb.genClr) genNext[shIdx] = 1'b0;
  end

  // Any shared source left with two or more CPU bits is an error
  always_comb begin
    errSet = 1'b0;
    for (int s = NUM_PERCPU; s < NUM_SRC; s++) begin
      int cnt;
      cnt = 0;
      for (int c = 0; c < NUM_CPUS; c++) cnt = cnt + int'(maskNext[c][s]);
      if (cnt > 1) errSet = 1'b1;
    end
  end

  // Per-CPU gating: shared sources pass the global enable, per-CPU ones do not
  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic [NUM_SRC-1:0] srcLive;
    assign srcLive = {shLevel & genEn, pcLevel[c*NUM_PERCPU +: NUM_PERCPU]};
    assign hit[c]  = |(srcLive & cpuMask[c]);
  end

  always_comb begin
    for (int c = 0; c < NUM_CPUS; c++) srcCol[c] = cpuMask[c][rdIdx];
  end

  always_comb begin
    if (stb.rdSrc)      rdNext = DATA_W'(srcCol);
    else if (stb.rdCpu) rdNext = DATA_W'(cpuMask[cpuSel]);
    else                rdNext = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CPUS; c++) cpuMask[c] <= '0;
      genEn     <= '0;
      errSticky <= 1'b0;
      cpuIrq    <= '0;
      rdData    <= '0;
    end else begin
      cpuMask   <= maskNext;
      genEn     <= genNext;
      errSticky <= errSticky | errSet;
      cpuIrq    <= hit;
      rdData    <= rdNext;
    end
  end

endmodule

// File: rtl/irq_route_top.sv
module irq_route_top
  import irq_route_pkg::*;
#(
  parameter int NUM_CPUS   = 4,
  parameter int NUM_SRC    = 32,
  parameter int NUM_PERCPU = 8,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int NUM_W      = 8,
  parameter int SET_BASE   = 64
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           busWrEn,
  input  logic                           busRdEn,
  input  logic [ADDR_W-1:0]              busAddr,
  input  logic [DATA_W-1:0]              busWrData,
  output logic [DATA_W-1:0]              busRdData,
  input  logic [NUM_SRC-NUM_PERCPU-1:0]  shLevel,
  input  logic [NUM_CPUS*NUM_PERCPU-1:0] pcLevel,
  output logic [NUM_CPUS-1:0]            cpuIrq,
  output logic                           errSticky
);

  localparam int IDX_W = $clog2(NUM_SRC);
  localparam int CPU_W = $clog2(NUM_CPUS);

  routeStb_t           stb;
  logic [IDX_W-1:0]    wrIdx, rdIdx;
  logic [CPU_W-1:0]    cpuSel;
  logic [NUM_CPUS-1:0] wrMask;

  irq_route_ctrl #(
    .NUM_CPUS(NUM_CPUS), .NUM_SRC(NUM_SRC), .NUM_PERCPU(NUM_PERCPU),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_W(NUM_W), .SET_BASE(SET_BASE)
  ) u_ctrl (
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr), .busWrData(busWrData),
    .stb(stb), .wrIdx(wrIdx), .rdIdx(rdIdx), .cpuSel(cpuSel), .wrMask(wrMask)
  );

  irq_route_dp #(
    .NUM_CPUS(NUM_CPUS), .NUM_SRC(NUM_SRC), .NUM_PERCPU(NUM_PERCPU), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .cpuSel(cpuSel), .wrMask(wrMask), .shLevel(shLevel), .pcLevel(pcLevel),
    .rdData(busRdData), .cpuIrq(cpuIrq), .errSticky(errSticky)
  );

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int NUM_CPUS   = 4,
  parameter int NUM_SRC    = 32,
  parameter int NUM_PERCPU = 8,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           busWrEn,
  input logic                           busRdEn,
  input logic [ADDR_W-1:0]              busAddr,
  input logic [DATA_W-1:0]              busWrData,
  input logic [DATA_W-1:0]              busRdData,
  input logic [NUM_SRC-NUM_PERCPU-1:0]  shLevel,
  input logic [NUM_CPUS*NUM_PERCPU-1:0] pcLevel,
  input logic [NUM_CPUS-1:0]            cpuIrq,
  input logic                           errSticky
);

  localparam logic [ADDR_W-1:0] SH_FIRST = ADDR_W'(NUM_PERCPU);
  localparam logic [ADDR_W-1:0] SRC_END  = ADDR_W'(NUM_SRC);

  // R11: once raised, the error flag stays until reset
  p_err_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    errSticky |=> errSticky);

  // R11: multi-CPU mask word written to a shared source raises the flag
  p_illegal_word_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr >= SH_FIRST && busAddr < SRC_END &&
     $countones(busWrData[NUM_CPUS-1:0]) > 1) |=> errSticky);

  // R7 / R8: with every raw level low, no CPU line is asserted next cycle
  p_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    (shLevel == '0 && pcLevel == '0) |=> (cpuIrq == '0));

  // R10: read data is zero after a cycle without a read strobe
  p_rd_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> (busRdData == '0));

  // R9: with levels steady and no write one cycle back, the lines hold
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(shLevel) && $stable(pcLevel) && !$past(busWrEn)) |=> $stable(cpuIrq));

endmodule

bind irq_route_top irq_route_chk #(
  .NUM_CPUS(NUM_CPUS), .NUM_SRC(NUM_SRC), .NUM_PERCPU(NUM_PERCPU),
  .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
  .busWrData(busWrData), .busRdData(busRdData), .shLevel(shLevel), .pcLevel(pcLevel),
  .cpuIrq(cpuIrq), .errSticky(errSticky)
);

// File: tb/irq_route_top_bench.sv
`timescale 1ns/1ps
module irq_route_top_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [23:0] shLevel = '0;
  logic [31:0] pcLevel = '0;
  logic [3:0]  cpuIrq;
  logic        errSticky;

  int  nRun = 0;
  int  nFail = 0;
  bit  done = 1'b0;
  logic rdSeen = 1'b0;

  typedef struct { logic [31:0] val; string tag; } rdExp_t;
  rdExp_t expQ[$];

  always #4 clk = ~clk;

  irq_route_top u_irq_route_top (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .shLevel(shLevel), .pcLevel(pcLevel),
    .cpuIrq(cpuIrq), .errSticky(errSticky)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  // Driver: pushes the expected read value, monitor compares it later
  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = a;
    expQ.push_back('{exp, tag});
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; shLevel = '0; pcLevel = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // Monitor: sees the sampled read strobe, then checks data on the falling edge
  always @(posedge clk) rdSeen <= busRdEn;

  always @(negedge clk) begin
    if (rdSeen) begin
      if (expQ.size() == 0) begin
        nRun++; nFail++;
        $display("FAIL R10: unexpected read data %h expected none", busRdData);
      end else begin
        rdExp_t e;
        e = expQ.pop_front();
        chk(e.tag, busRdData, e.val);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    doReset();
    @(negedge clk);
    // R1: reset state
    chk("R1 cpuIrq", 32'(cpuIrq), 0);
    chk("R1 errSticky", 32'(errSticky), 0);
    chk("R1/R10 idle read data", busRdData, 0);
    rd(8'h05, 0, "R1 source word");
    rd(8'h40, 0, "R1 cpu0 vector");

    // R2 / R4: per-source write seen in per-CPU window
    wr(8'h0A, 32'h4);
    rd(8'h0A, 32'h4, "R2 source 10 word");
    rd(8'h42, 32'h1 << 10, "R4 cpu2 vector");
    rd(8'h40, 0, "R4 cpu0 vector");
    wr(8'h06, 32'hFFFF_FFF9);
    rd(8'h06, 32'h9, "R2 upper data bits dropped");
    chk("R11 per-CPU source multi-route", 32'(errSticky), 0);

    // R3 / R4: per-CPU set seen in per-source window
    wr(8'h41, 3);
    wr(8'h43, 3);
    rd(8'h03, 32'ha, "R3 source 3 word");
    rd(8'h45, 32'h1 << 3, "R3 cpu1 vector via clear address");
    chk("R11 no error for per-CPU source", 32'(errSticky), 0);

    // R5: out-of-range numbers ignored
    wr(8'h40, 40);
    wr(8'h45, 35);
    rd(8'h40, 32'h1 << 6, "R5 cpu0 vector unchanged");
    rd(8'h41, 32'h1 << 3, "R5 cpu1 vector unchanged");

    // R7 / R6 / R9: shared source 10 routed to cpu2
    @(negedge clk); shLevel[2] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 no global enable", 32'(cpuIrq), 0);
    wr(8'h48, 10);
    chk("R9 not yet after enable write", 32'(cpuIrq), 0);
    @(negedge clk);
    chk("R7 shared routed to cpu2", 32'(cpuIrq), 32'h4);
    wr(8'h46, 10);
    @(negedge clk);
    chk("R7 mask cleared", 32'(cpuIrq), 0);
    rd(8'h0A, 0, "R4 source 10 word after per-CPU clear");
    @(negedge clk); shLevel[2] = 1'b0;

    // R8 / R9: per-CPU source 3
    @(negedge clk); pcLevel[1*8+3] = 1'b1; pcLevel[0*8+3] = 1'b1;
    @(negedge clk);
    chk("R8/R9 per-CPU level one edge later", 32'(cpuIrq), 32'h2);
    @(negedge clk); pcLevel = '0;
    @(negedge clk);
    chk("R8 level dropped", 32'(cpuIrq), 0);

    // R5 / R6: global enable numbering
    @(negedge clk); shLevel[4] = 1'b1;
    wr(8'h0C, 1);
    wr(8'h48, 44);
    @(negedge clk);
    chk("R5 enable number 44 ignored", 32'(cpuIrq), 0);
    wr(8'h48, 12);
    @(negedge clk);
    chk("R6 enable set source 12", 32'(cpuIrq), 32'h1);
    wr(8'h49, 12);
    @(negedge clk);
    chk("R6 enable cleared source 12", 32'(cpuIrq), 0);

    // R10: unmapped read
    rd(8'h60, 0, "R10 unmapped read");
    rd(8'h48, 0, "R10 enable address read");

    // R11: illegal multi-CPU word on shared source
    wr(8'h14, 3);
    chk("R11 flag on illegal word", 32'(errSticky), 1);
    wr(8'h14, 0);
    chk("R11 flag sticky", 32'(errSticky), 1);

    doReset();
    @(negedge clk);
    chk("R1 flag cleared by reset", 32'(errSticky), 0);
    rd(8'h0C, 0, "R1 source 12 word after reset");
    wr(8'h40, 15);
    chk("R11 single route legal", 32'(errSticky), 0);
    wr(8'h41, 15);
    chk("R11 flag via per-CPU window", 32'(errSticky), 1);

    repeat (3) @(negedge clk);
    chk("R10 read queue drained", 32'(expQ.size()), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule